// File: doc/BRIEF.md
# Two-cell pack guard

This block supervises a series pair of lithium cells. It drives one enable line to a pair of back-to-back low-side switch transistors and one low-power indication. Its inputs are condition flags that are already digitised: a class for each cell, pack undervoltage, charger presence, charger reversal, a qualified overcharge trip, a load short, a load-removed flag and an open center tap. A periodic oscillator tick paces the duty cycling.

The switch is held on, held off, or modulated in frames of eight ticks. The modulation runs at 7/8 duty while an over-discharged pack charges and at 1/8 duty while an undervoltage pack charges. While the controller cycles, it trusts the charger flag only in the last slot of each frame, because the switch is open then and the reading is meaningful. Each fault class releases in its own way. A short stays latched until the load is removed. Shutdown ends only when a charger appears. An open tap keeps the switch off until the tap reconnects.

All state is registered. Both outputs depend only on registers and change on the clock edge that samples the causing condition.

Top module: `cellpair_guard`

## Requirements
- R1: Asserting the active-low reset asynchronously forces `shutdown` high and `gate_en` low, and the controller stays in shutdown after reset is released.
- R2: In shutdown the controller stays in shutdown with the switch off for as long as `chg_present` is low, whatever the cells read. When `chg_present` is high it leaves shutdown to the mode that the current conditions select.
- R3: Cell codes are 2'b00 over-discharged, 2'b01 normal, 2'b10 overcharged, and 2'b11 is treated as overcharged. With both cells normal, no other fault, and the controller out of shutdown, `gate_en` is held high whether or not a charger is present.
- R4: An overcharged cell together with `oc_trip` and `chg_present` turns the switch off. The same cell with no charger present keeps the switch on so the pack can feed the load.
- R5: A cell reading over-discharged with no charger present sends the controller into shutdown with the switch off.
- R6: An over-discharged cell with a charger present cycles the switch at 7/8 duty. A frame is eight slots, each tick advances one slot, and the switch is on in slots 0 to 6 and off in slot 7. A frame starts at slot 0 when cycling begins. When both cells read normal again, the switch goes continuously on.
- R7: While cycling, the charger flag is examined only on a tick in slot 7. If the charger is absent there and the undervoltage or over-discharge cause remains, the controller shuts down. A missing charger in any other slot has no effect.
- R8: Pack undervoltage with a charger present cycles the switch at 1/8 duty, on in slot 0 only. When undervoltage clears while a cell is still over-discharged, cycling moves to 7/8 duty and the slot count carries on.
- R9: Outside shutdown, `load_short` turns the switch off at the next clock edge. The switch stays off until `load_gone` is seen with the short cleared.
- R10: `chg_reversed` turns the switch off for as long as it is asserted.
- R11: An open center tap keeps the switch off until reconnection. The exception is undervoltage with a charger present, which runs 1/8 duty. If undervoltage clears while the tap is still open, the switch goes off.
- R12: When several conditions hold at once, they rank in this order: short, reversed charger, open tap, undervoltage, over-discharge, overcharge trip, normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle oscillator pulse that advances the duty slot |
| cell_hi | input | 2 | Class code of the upper cell |
| cell_lo | input | 2 | Class code of the lower cell |
| pack_uv | input | 1 | Whole pack below the undervoltage level |
| chg_present | input | 1 | Charger detected |
| chg_reversed | input | 1 | Charger connected with reversed polarity |
| oc_trip | input | 1 | Overcharge qualified by the external delay logic |
| load_short | input | 1 | Load current above the short limit |
| load_gone | input | 1 | Load removal detected |
| tap_open | input | 1 | Center tap disconnected |
| gate_en | output | 1 | Switch enable |
| shutdown | output | 1 | Low-power shutdown indication |

## Verification
A mode register holding the wrong state appears on the ports at the next edge. It shows as `gate_en` high where a fault should hold it low, or as `shutdown` set or cleared at the wrong moment. A slot counter that drifts appears within one frame, as an off slot that lands in the wrong position or a 1/8 pulse that is missing. A wrong charger-check slot appears as an early shutdown, or as a shutdown that never happens once the charger has gone. The bench walks every transition in the requirements and compares both outputs after each edge.

// File: rtl/cpg_pkg.sv
`timescale 1ns/1ps
package cpg_pkg;

  localparam logic [1:0] CELL_ODC  = 2'b00;
  localparam logic [1:0] CELL_NORM = 2'b01;

  typedef enum logic [2:0] {
    M_SHDN,
    M_RUN,
    M_OCHOLD,
    M_SHORT,
    M_REVERSE,
    M_TAPOFF,
    M_DUTY_HI,
    M_DUTY_LO
  } mode_t;

  // Priority selection of the wanted mode (R12 order).
  function automatic mode_t cpg_pick(input logic shrt, input logic rev,
                                     input logic tap, input logic uv,
                                     input logic odc, input logic oc_hit,
                                     input logic chg);
    if (shrt)        return M_SHORT;
    else if (rev)    return M_REVERSE;
    else if (tap)    return (uv && chg) ? M_DUTY_LO : M_TAPOFF;
    else if (uv)     return chg ? M_DUTY_LO : M_SHDN;
    else if (odc)    return chg ? M_DUTY_HI : M_SHDN;
    else if (oc_hit) return chg ? M_OCHOLD : M_RUN;
    else             return M_RUN;
  endfunction

  function automatic logic cpg_cycling(input mode_t m);
    return (m == M_DUTY_HI) || (m == M_DUTY_LO);
  endfunction

endpackage

// File: rtl/cpg_arbiter.sv
`timescale 1ns/1ps
module cpg_arbiter
  import cpg_pkg::*;
(
  input  logic [1:0] cell_hi,
  input  logic [1:0] cell_lo,
  input  logic       pack_uv,
  input  logic       chg_eff,
  input  logic       chg_reversed,
  input  logic       oc_trip,
  input  logic       load_short,
  input  logic       tap_open,
  output mode_t      target
);
  logic any_odc;
  logic any_oc;

  assign any_odc = (cell_hi == CELL_ODC) || (cell_lo == CELL_ODC);
  assign any_oc  = cell_hi[1] | cell_lo[1];

  assign target = cpg_pick(load_short, chg_reversed, tap_open, pack_uv,
                           any_odc, any_oc & oc_trip, chg_eff);
endmodule

// File: rtl/cpg_duty.sv
`timescale 1ns/1ps
module cpg_duty
  import cpg_pkg::*;
#(
  parameter int FRAME_LEN = 8,
  parameter int LONG_ON   = 7,
  parameter int SHORT_ON  = 1,
  localparam int SLOT_W   = $clog2(FRAME_LEN)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  mode_t             mode_q,
  output logic [SLOT_W-1:0] slot_q,
  output logic              chk_point,
  output logic              gate_en
);
  localparam logic [SLOT_W-1:0] LAST      = SLOT_W'(FRAME_LEN - 1);
  localparam logic [SLOT_W-1:0] LONG_CUT  = SLOT_W'(LONG_ON);
  localparam logic [SLOT_W-1:0] SHORT_CUT = SLOT_W'(SHORT_ON);

  logic              cyc;
  logic [SLOT_W-1:0] slot_nx;

  assign cyc = cpg_cycling(mode_q);

  generate
    if (FRAME_LEN == (1 << SLOT_W)) begin : g_wrap_free
      assign slot_nx = slot_q + 1'b1;
    end else begin : g_wrap_cmp
      assign slot_nx = (slot_q == LAST) ? '0 : slot_q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    slot_q <= '0;
    else if (!cyc) slot_q <= '0;
    else if (tick) slot_q <= slot_nx;
  end

  assign chk_point = cyc && tick && (slot_q == LAST);

  always_comb begin
    unique case (mode_q)
      M_RUN:     gate_en = 1'b1;
      M_DUTY_HI: gate_en = (slot_q < LONG_CUT);
      M_DUTY_LO: gate_en = (slot_q < SHORT_CUT);
      default:   gate_en = 1'b0;
    endcase
  end
endmodule

// File: rtl/cpg_fsm.sv
`timescale 1ns/1ps
module cpg_fsm
  import cpg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  mode_t target,
  input  logic  chg_present,
  input  logic  chk_point,
  input  logic  load_short,
  input  logic  load_gone,
  output mode_t mode_q,
  output logic  chg_eff
);
  mode_t mode_nx;

  // While cycling, the charger reading counts only at the check point.
  assign chg_eff = cpg_cycling(mode_q) ? (chk_point ? chg_present : 1'b1)
                                       : chg_present;

  always_comb begin
    unique case (mode_q)
      M_SHDN:  mode_nx = chg_present ? target : M_SHDN;
      M_SHORT: mode_nx = (load_gone && !load_short) ? target : M_SHORT;
      default: mode_nx = target;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= M_SHDN;
    else        mode_q <= mode_nx;
  end
endmodule

// File: rtl/cellpair_guard.sv
`timescale 1ns/1ps
module cellpair_guard
  import cpg_pkg::*;
#(
  parameter int FRAME_LEN = 8,
  parameter int LONG_ON   = 7,
  parameter int SHORT_ON  = 1
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] cell_hi,
  input  logic [1:0] cell_lo,
  input  logic       pack_uv,
  input  logic       chg_present,
  input  logic       chg_reversed,
  input  logic       oc_trip,
  input  logic       load_short,
  input  logic       load_gone,
  input  logic       tap_open,
  output logic       gate_en,
  output logic       shutdown
);
  localparam int SLOT_W = $clog2(FRAME_LEN);

  mode_t             mode_q;
  mode_t             target;
  logic              chg_eff;
  logic              chk_point;
  logic [SLOT_W-1:0] slot_q;

  cpg_arbiter u_arb (
    .cell_hi      (cell_hi),
    .cell_lo      (cell_lo),
    .pack_uv      (pack_uv),
    .chg_eff      (chg_eff),
    .chg_reversed (chg_reversed),
    .oc_trip      (oc_trip),
    .load_short   (load_short),
    .tap_open     (tap_open),
    .target       (target)
  );

  cpg_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .target      (target),
    .chg_present (chg_present),
    .chk_point   (chk_point),
    .load_short  (load_short),
    .load_gone   (load_gone),
    .mode_q      (mode_q),
    .chg_eff     (chg_eff)
  );

  cpg_duty #(
    .FRAME_LEN (FRAME_LEN),
    .LONG_ON   (LONG_ON),
    .SHORT_ON  (SHORT_ON)
  ) u_duty (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .mode_q    (mode_q),
    .slot_q    (slot_q),
    .chk_point (chk_point),
    .gate_en   (gate_en)
  );

  assign shutdown = (mode_q == M_SHDN);
endmodule

// File: rtl/cpg_checker.sv
`timescale 1ns/1ps
module cpg_checker
  import cpg_pkg::*;
#(
  parameter int FRAME_LEN = 8,
  localparam int SLOT_W   = $clog2(FRAME_LEN)
)(
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        cell_hi,
  input logic [1:0]        cell_lo,
  input logic              pack_uv,
  input logic              chg_present,
  input logic              chg_reversed,
  input logic              load_short,
  input logic              load_gone,
  input logic              tap_open,
  input logic              gate_en,
  input logic              shutdown,
  input mode_t             mode_q,
  input logic [SLOT_W-1:0] slot_q,
  input logic              chk_point
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(FRAME_LEN - 1);
  logic odc_seen;
  assign odc_seen = (cell_hi == 2'b00) || (cell_lo == 2'b00);

  // R1
  shdn_gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> !gate_en);

  // R2
  shdn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown && !chg_present) |=> shutdown);

  // R6
  duty_hi_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_DUTY_HI && slot_q != LAST) |-> gate_en);

  // R7
  charger_lost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_point && !chg_present && !load_short && !chg_reversed && !tap_open
     && (pack_uv || odc_seen)) |=> shutdown);

  // R8
  duty_lo_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_DUTY_LO && slot_q != '0) |-> !gate_en);

  // R9
  short_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_short |=> !gate_en);

  // R9
  short_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SHORT && !load_gone) |=> !gate_en);

  // R10
  reversed_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg_reversed |=> !gate_en);

  // R11
  tap_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_open && !pack_uv) |=> !gate_en);
endmodule

bind cellpair_guard cpg_checker #(.FRAME_LEN(FRAME_LEN)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cell_hi      (cell_hi),
  .cell_lo      (cell_lo),
  .pack_uv      (pack_uv),
  .chg_present  (chg_present),
  .chg_reversed (chg_reversed),
  .load_short   (load_short),
  .load_gone    (load_gone),
  .tap_open     (tap_open),
  .gate_en      (gate_en),
  .shutdown     (shutdown),
  .mode_q       (mode_q),
  .slot_q       (slot_q),
  .chk_point    (chk_point)
);

// File: tb/sim_cellpair_guard.sv
`timescale 1ns/1ps
module sim_cellpair_guard;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] cell_hi = 2'b01;
  logic [1:0] cell_lo = 2'b01;
  logic       pack_uv = 1'b0;
  logic       chg_present = 1'b0;
  logic       chg_reversed = 1'b0;
  logic       oc_trip = 1'b0;
  logic       load_short = 1'b0;
  logic       load_gone = 1'b0;
  logic       tap_open = 1'b0;
  logic       gate_en;
  logic       shutdown;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic  g;
    logic  s;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  cellpair_guard u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cell_hi(cell_hi), .cell_lo(cell_lo),
    .pack_uv(pack_uv), .chg_present(chg_present), .chg_reversed(chg_reversed),
    .oc_trip(oc_trip), .load_short(load_short), .load_gone(load_gone),
    .tap_open(tap_open), .gate_en(gate_en), .shutdown(shutdown)
  );

  task automatic compare(input logic g, input logic s, input string tag);
    checks++;
    if (gate_en !== g || shutdown !== s) begin
      errors++;
      $display("FAIL %s: gate_en=%0b shutdown=%0b expected gate_en=%0b shutdown=%0b",
               tag, gate_en, shutdown, g, s);
    end
  endtask

  // Monitor: pops one expectation per falling edge.
  always @(negedge clk) begin
    exp_t e;
    if (sb.size() > 0) begin
      e = sb.pop_front();
      compare(e.g, e.s, e.tag);
    end
  end

  // Driver: one clock edge with the given tick, then queue the expectation.
  task automatic step(input logic tk, input logic eg, input logic es, input string tag);
    exp_t e;
    tick = tk;
    @(posedge clk);
    #1;
    tick = 1'b0;
    e.g = eg; e.s = es; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not end, actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare(1'b0, 1'b1, "R1 reset state");
    rst_n = 1'b1;
    @(negedge clk);

    // R2: no charger keeps shutdown even with normal cells
    step(1'b0, 1'b0, 1'b1, "R2 hold no charger");
    step(1'b1, 1'b0, 1'b1, "R2 hold with tick");
    chg_present = 1'b1;
    step(1'b0, 1'b1, 1'b0, "R2 exit on charger");
    chg_present = 1'b0;
    step(1'b0, 1'b1, 1'b0, "R3 normal without charger");

    // R4 overcharge
    cell_hi = 2'b10; oc_trip = 1'b1; chg_present = 1'b1;
    step(1'b0, 1'b0, 1'b0, "R4 trip with charger");
    chg_present = 1'b0;
    step(1'b0, 1'b1, 1'b0, "R4 trip feeding load");
    cell_hi = 2'b11; chg_present = 1'b1;
    step(1'b0, 1'b0, 1'b0, "R3 code 11 as overcharged");
    cell_hi = 2'b01; oc_trip = 1'b0;
    step(1'b0, 1'b1, 1'b0, "R3 normal with charger");
    chg_present = 1'b0;

    // R9 short latch
    load_short = 1'b1;
    step(1'b0, 1'b0, 1'b0, "R9 short cuts switch");
    load_short = 1'b0;
    step(1'b0, 1'b0, 1'b0, "R9 held until load removed");
    load_gone = 1'b1;
    step(1'b0, 1'b1, 1'b0, "R9 release on load removed");
    load_gone = 1'b0;

    // R10 reversed
    chg_reversed = 1'b1;
    step(1'b0, 1'b0, 1'b0, "R10 reversed off");
    step(1'b0, 1'b0, 1'b0, "R10 reversed stays off");
    chg_reversed = 1'b0;
    step(1'b0, 1'b1, 1'b0, "R10 reversal cleared");

    // R11 tap open
    tap_open = 1'b1;
    step(1'b0, 1'b0, 1'b0, "R11 tap open off");
    step(1'b1, 1'b0, 1'b0, "R11 tap open held");
    tap_open = 1'b0;
    step(1'b0, 1'b1, 1'b0, "R11 tap reconnected");

    // R6 7/8 duty
    cell_lo = 2'b00; chg_present = 1'b1;
    step(1'b0, 1'b1, 1'b0, "R6 duty entry slot0");
    for (int k = 1; k < 8; k++) step(1'b1, (k < 7), 1'b0, "R6 duty slot");
    step(1'b1, 1'b1, 1'b0, "R7 charger seen keeps cycling");
    chg_present = 1'b0;
    for (int k = 1; k < 8; k++) step(1'b1, (k < 7), 1'b0, "R7 absence ignored off check slot");
    step(1'b1, 1'b0, 1'b1, "R7 absence at check slot shuts down");

    // R6 recovery to continuous on
    chg_present = 1'b1;
    step(1'b0, 1'b1, 1'b0, "R6 re-enter duty from shutdown");
    cell_lo = 2'b01;
    step(1'b0, 1'b1, 1'b0, "R6 cells normal");
    for (int k = 0; k < 8; k++) step(1'b1, 1'b1, 1'b0, "R6 continuous on");

    // R8 1/8 duty
    pack_uv = 1'b1;
    step(1'b0, 1'b1, 1'b0, "R8 uv entry slot0");
    for (int k = 1; k < 8; k++) step(1'b1, 1'b0, 1'b0, "R8 uv off slot");
    step(1'b1, 1'b1, 1'b0, "R8 uv frame wraps to slot0");
    pack_uv = 1'b0; cell_lo = 2'b00;
    step(1'b0, 1'b1, 1'b0, "R8 uv cleared moves to 7/8");
    step(1'b1, 1'b1, 1'b0, "R8 slot1 now on");
    cell_lo = 2'b01;
    step(1'b0, 1'b1, 1'b0, "R6 back to run");

    // R5 / uv without charger
    cell_lo = 2'b00; chg_present = 1'b0;
    step(1'b0, 1'b0, 1'b1, "R5 over-discharge shuts down");
    cell_lo = 2'b01;
    step(1'b0, 1'b0, 1'b1, "R2 cells recover no charger");

    // R11 exception: uv + charger with tap open
    tap_open = 1'b1; pack_uv = 1'b1; chg_present = 1'b1;
    step(1'b0, 1'b1, 1'b0, "R11 tap open uv charging");
    step(1'b1, 1'b0, 1'b0, "R11 tap open 1/8 off slot");
    pack_uv = 1'b0;
    step(1'b0, 1'b0, 1'b0, "R11 uv cleared with tap open");
    tap_open = 1'b0;
    step(1'b0, 1'b1, 1'b0, "R11 tap back");

    // R12 priority
    load_short = 1'b1; chg_reversed = 1'b1; tap_open = 1'b1;
    step(1'b0, 1'b0, 1'b0, "R12 short over others");
    load_short = 1'b0; load_gone = 1'b1;
    step(1'b0, 1'b0, 1'b0, "R12 reversed next");
    load_gone = 1'b0; chg_reversed = 1'b0; pack_uv = 1'b1;
    step(1'b0, 1'b1, 1'b0, "R12 tap open with uv and charger");
    tap_open = 1'b0; pack_uv = 1'b0; cell_hi = 2'b00; oc_trip = 1'b1; cell_lo = 2'b10;
    step(1'b0, 1'b1, 1'b0, "R12 over-discharge over overcharge");
    step(1'b1, 1'b1, 1'b0, "R12 still 7/8");
    cell_hi = 2'b01; cell_lo = 2'b01; oc_trip = 1'b0;
    step(1'b0, 1'b1, 1'b0, "R3 normal again");

    // R1 asynchronous reset
    #1;
    rst_n = 1'b0;
    #1;
    compare(1'b0, 1'b1, "R1 async reset");
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 1'b1, 1'b0, "R2 exit after reset with charger");

    @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule